// File: doc/BRIEF.md
# Byte-Addressed Program Counter

This block holds the program counter of a processor whose program store is organised in bytes while every instruction is built from 16-bit words. Each instruction is one or two words long. The counter always names an even byte address. Each update applies one of four moves: step to the next word, step past a two-word instruction, load an absolute target, or take a relative branch. Absolute targets arrive as word numbers and are scaled to bytes. Relative offsets count instruction words and are taken from the address of the following instruction.

A small operation-class input comes from the instruction decoder, and an `advance` strobe tells the block when to apply it. The block presents the current fetch byte address. It also merges the two bytes read from the store, the even lane and the odd lane, into the little-endian instruction word that goes to decode.

Top module: `prog_counter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) sets `fetchAddr` to 000000h.
- R2: With `advance` high and `opClass` = 0 (sequential), `fetchAddr` grows by 2 at the clock edge.
- R3: With `advance` high and `opClass` = 1 (two-word step), `fetchAddr` grows by 4 at the clock edge. This moves it past both words of a long instruction.
- R4: With `advance` high and `opClass` = 2 (absolute), `fetchAddr` becomes twice `absWordAddr`. Word target 000003h gives byte address 000006h.
- R5: With `advance` high and `opClass` = 3 (relative), `fetchAddr` becomes old `fetchAddr` + 2 + 2 × `relOffset`. `relOffset` is read as a signed two's-complement word count, so an offset of -1 branches to the branch itself.
- R6: With `advance` low and `rst` low, `fetchAddr` keeps its value whatever `opClass`, `absWordAddr` and `relOffset` carry.
- R7: Every result wraps modulo 2^21. A sequential step from 1FFFFEh gives 000000h, and a two-word step from 1FFFFEh gives 000002h.
- R8: Bit 0 of `fetchAddr` reads 0 at all times.
- R9: `instrWord` equals `oddByte` in bits 15:8 and `evenByte` in bits 7:0, with no clock delay.
- R10: When `rst` and `advance` are both high at the same edge, the reset wins and `fetchAddr` becomes 000000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Apply the selected PC operation at this edge |
| opClass | input | 2 | 0 sequential, 1 two-word step, 2 absolute, 3 relative |
| absWordAddr | input | 20 | Absolute target as a word address |
| relOffset | input | 11 | Signed relative offset in instruction words |
| evenByte | input | 8 | Byte read from the even address of the fetched word |
| oddByte | input | 8 | Byte read from the odd address of the fetched word |
| fetchAddr | output | 21 | Current program counter as a byte address |
| instrWord | output | 16 | Assembled little-endian instruction word |

## Verification
A reset can arrive in the same cycle as an `advance` carrying any operation, and only one of them can set the next counter. The bench raises `rst` together with `advance` and with absolute or relative operations whose targets are nonzero. It then expects 000000h on the next cycle and not the jump target. The bench also sends random operations while the byte lanes change, and checks the assembled word against the lanes in the same cycles in which the counter moves.

// File: rtl/pc_pkg.sv
package pc_pkg;

  typedef enum logic [1:0] {
    OP_SEQ  = 2'd0,
    OP_LONG = 2'd1,
    OP_ABS  = 2'd2,
    OP_REL  = 2'd3
  } opClass_e;

  typedef struct packed {
    logic clear;
    logic stepOne;
    logic stepTwo;
    logic loadAbs;
    logic addRel;
  } pcStrobe_t;

endpackage

// File: rtl/pc_ctrl.sv
module pc_ctrl
  import pc_pkg::*;
(
  input  logic       rst,
  input  logic       advance,
  input  logic [1:0] opClass,
  output pcStrobe_t  strobe
);

  opClass_e op;

  assign op = opClass_e'(opClass);

  always_comb begin
    strobe = '0;
    if (rst) begin
      strobe.clear = 1'b1;
    end else if (advance) begin
      unique case (op)
        OP_SEQ:  strobe.stepOne = 1'b1;
        OP_LONG: strobe.stepTwo = 1'b1;
        OP_ABS:  strobe.loadAbs = 1'b1;
        OP_REL:  strobe.addRel  = 1'b1;
        default: strobe.stepOne = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/pc_datapath.sv
module pc_datapath
  import pc_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int OFF_W = 11
) (
  input  logic              clk,
  input  pcStrobe_t         strobe,
  input  logic [PC_W-2:0]   absWordAddr,
  input  logic [OFF_W-1:0]  relOffset,
  output logic [PC_W-1:0]   fetchAddr
);

  localparam int WADDR_W = PC_W - 1;
  localparam int EXT_W   = WADDR_W - OFF_W;

  logic [WADDR_W-1:0] pcWord;
  logic [WADDR_W-1:0] pcWordNext;
  logic [WADDR_W-1:0] seqWord;
  logic [WADDR_W-1:0] offWord;

  assign seqWord = pcWord + WADDR_W'(1);
  assign offWord = {{EXT_W{relOffset[OFF_W-1]}}, relOffset};

  always_comb begin
    pcWordNext = pcWord;
    if (strobe.stepOne) pcWordNext = seqWord;
    if (strobe.stepTwo) pcWordNext = pcWord + WADDR_W'(2);
    if (strobe.loadAbs) pcWordNext = absWordAddr;
    if (strobe.addRel)  pcWordNext = seqWord + offWord;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) pcWord <= '0;
    else              pcWord <= pcWordNext;
  end

  assign fetchAddr = {pcWord, 1'b0};

endmodule

// File: rtl/word_join.sv
module word_join #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic [LANES*BYTE_W-1:0] laneBus,
  output logic [LANES*BYTE_W-1:0] word
);

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign word[lane*BYTE_W +: BYTE_W] = laneBus[lane*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/prog_counter.sv
module prog_counter
  import pc_pkg::*;
#(
  parameter int PC_W   = 21,
  parameter int OFF_W  = 11,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                advance,
  input  logic [1:0]          opClass,
  input  logic [PC_W-2:0]     absWordAddr,
  input  logic [OFF_W-1:0]    relOffset,
  input  logic [BYTE_W-1:0]   evenByte,
  input  logic [BYTE_W-1:0]   oddByte,
  output logic [PC_W-1:0]     fetchAddr,
  output logic [2*BYTE_W-1:0] instrWord
);

  localparam int LANES = 2;

  pcStrobe_t strobe;

  pc_ctrl u_ctrl (
    .rst     (rst),
    .advance (advance),
    .opClass (opClass),
    .strobe  (strobe)
  );

  pc_datapath #(
    .PC_W  (PC_W),
    .OFF_W (OFF_W)
  ) u_dp (
    .clk         (clk),
    .strobe      (strobe),
    .absWordAddr (absWordAddr),
    .relOffset   (relOffset),
    .fetchAddr   (fetchAddr)
  );

  word_join #(
    .BYTE_W (BYTE_W),
    .LANES  (LANES)
  ) u_join (
    .laneBus ({oddByte, evenByte}),
    .word    (instrWord)
  );

endmodule

// File: rtl/prog_counter_chk.sv
module prog_counter_chk #(
  parameter int PC_W   = 21,
  parameter int OFF_W  = 11,
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                advance,
  input logic [1:0]          opClass,
  input logic [PC_W-2:0]     absWordAddr,
  input logic [OFF_W-1:0]    relOffset,
  input logic [BYTE_W-1:0]   evenByte,
  input logic [BYTE_W-1:0]   oddByte,
  input logic [PC_W-1:0]     fetchAddr,
  input logic [2*BYTE_W-1:0] instrWord
);

  localparam logic [PC_W-1:0] STEP2 = PC_W'(2);
  localparam logic [PC_W-1:0] STEP4 = PC_W'(4);

  logic [PC_W-1:0] relBytes;
  assign relBytes = {{(PC_W-OFF_W-1){relOffset[OFF_W-1]}}, relOffset, 1'b0};

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> fetchAddr == '0);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && opClass == 2'd0) |=> fetchAddr == $past(fetchAddr) + STEP2);

  // R3
  long_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && opClass == 2'd1) |=> fetchAddr == $past(fetchAddr) + STEP4);

  // R4
  abs_load_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && opClass == 2'd2) |=> fetchAddr == {$past(absWordAddr), 1'b0});

  // R5
  rel_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && opClass == 2'd3) |=>
      fetchAddr == $past(fetchAddr) + STEP2 + $past(relBytes));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(fetchAddr));

  // R9
  always_comb begin
    word_join_chk: assert (instrWord[BYTE_W-1:0] == evenByte &&
                           instrWord[2*BYTE_W-1:BYTE_W] == oddByte);
  end

endmodule

bind prog_counter prog_counter_chk #(
  .PC_W   (PC_W),
  .OFF_W  (OFF_W),
  .BYTE_W (BYTE_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .advance     (advance),
  .opClass     (opClass),
  .absWordAddr (absWordAddr),
  .relOffset   (relOffset),
  .evenByte    (evenByte),
  .oddByte     (oddByte),
  .fetchAddr   (fetchAddr),
  .instrWord   (instrWord)
);

// File: tb/prog_counter_bench.sv
`timescale 1ns/1ps
module prog_counter_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        advance = 1'b0;
  logic [1:0]  opClass = 2'd0;
  logic [19:0] absWordAddr = '0;
  logic [10:0] relOffset = '0;
  logic [7:0]  evenByte = '0;
  logic [7:0]  oddByte = '0;
  logic [20:0] fetchAddr;
  logic [15:0] instrWord;

  int checks = 0;
  int errors = 0;
  logic [20:0] expPc = '0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  prog_counter u_prog_counter (
    .clk(clk), .rst(rst), .advance(advance), .opClass(opClass),
    .absWordAddr(absWordAddr), .relOffset(relOffset),
    .evenByte(evenByte), .oddByte(oddByte),
    .fetchAddr(fetchAddr), .instrWord(instrWord)
  );

  function automatic logic [20:0] nextPc(logic [20:0] pc, logic r, logic adv,
                                         logic [1:0] op, logic [19:0] w,
                                         logic [10:0] off);
    if (r) return 21'd0;
    if (!adv) return pc;
    case (op)
      2'd0: return pc + 21'd2;
      2'd1: return pc + 21'd4;
      2'd2: return {w, 1'b0};
      default: return pc + 21'd2 + {{9{off[10]}}, off, 1'b0};
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply one cycle of stimulus from a negedge, then check after the posedge.
  task automatic cycle(string tag, logic r, logic adv, logic [1:0] op,
                       logic [19:0] w, logic [10:0] off);
    rst = r; advance = adv; opClass = op; absWordAddr = w; relOffset = off;
    evenByte = 8'($urandom); oddByte = 8'($urandom);
    #1;
    check("R9 word join", 32'(instrWord), 32'({oddByte, evenByte}));
    expPc = nextPc(expPc, r, adv, op, w, off);
    @(posedge clk);
    #2;
    check(tag, 32'(fetchAddr), 32'(expPc));
    check("R8 bit0", 32'(fetchAddr[0]), 32'd0);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    cycle("R1 reset", 1'b1, 1'b0, 2'd0, 20'h0, 11'h0);
    cycle("R2 seq", 1'b0, 1'b1, 2'd0, 20'h0, 11'h0);
    cycle("R3 long", 1'b0, 1'b1, 2'd1, 20'h0, 11'h0);
    cycle("R4 abs word 3", 1'b0, 1'b1, 2'd2, 20'h00003, 11'h0);
    check("R4 abs byte 6", 32'(fetchAddr), 32'h6);
    cycle("R5 rel self", 1'b0, 1'b1, 2'd3, 20'h0, 11'h7FF);
    cycle("R5 rel max pos", 1'b0, 1'b1, 2'd3, 20'h0, 11'h3FF);
    cycle("R5 rel max neg", 1'b0, 1'b1, 2'd3, 20'h0, 11'h400);
    cycle("R6 hold", 1'b0, 1'b0, 2'd2, 20'hABCDE, 11'h123);
    cycle("R6 hold rel", 1'b0, 1'b0, 2'd3, 20'h12345, 11'h7F0);
    cycle("R7 abs top", 1'b0, 1'b1, 2'd2, 20'hFFFFF, 11'h0);
    cycle("R7 seq wrap", 1'b0, 1'b1, 2'd0, 20'h0, 11'h0);
    check("R7 wrap zero", 32'(fetchAddr), 32'h0);
    cycle("R7 abs top", 1'b0, 1'b1, 2'd2, 20'hFFFFF, 11'h0);
    cycle("R7 long wrap", 1'b0, 1'b1, 2'd1, 20'h0, 11'h0);
    check("R7 long wrap 2", 32'(fetchAddr), 32'h2);
    cycle("R7 rel back wrap", 1'b0, 1'b1, 2'd3, 20'h0, 11'h7FC);
    cycle("R10 rst vs abs", 1'b1, 1'b1, 2'd2, 20'h55555, 11'h0);
    cycle("R4 abs", 1'b0, 1'b1, 2'd2, 20'h12345, 11'h0);
    cycle("R10 rst vs rel", 1'b1, 1'b1, 2'd3, 20'h0, 11'h100);
    for (int i = 0; i < 400; i++) begin
      logic r;
      r = ($urandom % 40) == 0;
      cycle("R2/R3/R4/R5/R6/R10 random", r, 1'($urandom % 4 != 0),
            2'($urandom), 20'($urandom), 11'($urandom));
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule